// File: doc/BRIEF.md
# Register-Mapped GCD Accelerator

This block computes the greatest common divisor of two unsigned operands for a host. The host talks to it through one request channel and one response channel, each with a valid/ready handshake. A request carries five fields: a kind (read or write), a register address, a data word, an opaque tag and an id. Writes to the two operand registers load the inputs. A read of the result register starts the computation, and the block answers that read only when the result is ready. No separate start or status register exists.

The datapath is iterative. In each cycle it either swaps the two working values or subtracts the smaller value from the larger. When the second working value reaches zero, the first one is the result. The block handles one request at a time. While a computation runs it accepts no new request. A response waits in the output register until the host takes it.

An access to an address that is not legal for its kind sets a sticky error flag. The block still answers that access, so the host can never deadlock.

Top module: `gcd_regacc`

## Requirements
- R1: After reset, `resp_valid` and `err_flag` are 0, and `req_ready` is 1.
- R2: A write to address 1 loads operand A, and a write to address 2 loads operand B (`req_write`=1 means write). In both cases the response comes one cycle after acceptance, with `resp_write`=1, `resp_data`=0, and the request's opaque and id echoed.
- R3: A read of address 0 (`req_write`=0) starts the computation. Its response has `resp_write`=0, carries gcd(A,B) in `resp_data`, and echoes that read's opaque and id.
- R4: gcd(0,0)=0. gcd(x,0)=x and gcd(0,x)=x. Otherwise the result is the largest integer that divides both operands.
- R5: While a computation is in progress, `req_ready` is 0 and no response is presented.
- R6: While `resp_valid`=1 and `resp_ready`=0, the response and all its fields stay unchanged, and `req_ready` is 0.
- R7: A write to any address other than 1 or 2, or a read of any address other than 0, sets `err_flag` and leaves both operands unchanged. It still gets a response of its own kind with `resp_data`=0 and its tags echoed.
- R8: Once set, `err_flag` stays 1 until reset.
- R9: A new request is accepted in the same cycle that the pending response is taken (`resp_valid`, `resp_ready` and `req_valid` all 1). The new request's response then replaces the old one on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_data | input | DATA_W | Write data |
| req_opaque | input | OPQ_W | Host tag, echoed |
| req_id | input | ID_W | Host id, echoed |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Host takes the response |
| resp_write | output | 1 | Kind of the answered request |
| resp_data | output | DATA_W | Result, or 0 |
| resp_opaque | output | OPQ_W | Echoed tag |
| resp_id | output | ID_W | Echoed id |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
Two events can fall in the same cycle: the host taking the pending response, and the block accepting the next request. The bench provokes this by holding `resp_ready` high and presenting a second write right after the first is accepted. It checks three things: `req_ready` is high in that cycle, the response on the next cycle carries the second request's tag, and a later read shows that both operands were loaded. A separate case holds `resp_ready` low to check that the response stays frozen and that the request side stays closed while it waits.

// File: rtl/gcd_regacc_pkg.sv
package gcd_regacc_pkg;
  localparam int unsigned REG_RESULT = 0;
  localparam int unsigned REG_OPA    = 1;
  localparam int unsigned REG_OPB    = 2;

  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/gcd_regacc_decode.sv
module gcd_regacc_decode
  import gcd_regacc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              start,
  output logic              illegal,
  output logic              err_flag
);
  logic hit_res, hit_a, hit_b;
  logic ld_a, ld_b;

  assign hit_res = (addr == ADDR_W'(REG_RESULT));
  assign hit_a   = (addr == ADDR_W'(REG_OPA));
  assign hit_b   = (addr == ADDR_W'(REG_OPB));

  assign illegal = is_write ? !(hit_a || hit_b) : !hit_res;
  assign ld_a    = fire && is_write && hit_a;
  assign ld_b    = fire && is_write && hit_b;
  assign start   = fire && !is_write && hit_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa      <= '0;
      opb      <= '0;
      err_flag <= 1'b0;
    end else begin
      if (ld_a) opa <= data;
      if (ld_b) opb <= data;
      if (fire && illegal) err_flag <= 1'b1;
    end
  end

  p_err_on_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && illegal |=> err_flag);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_illegal_keeps_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && illegal |=> $stable(opa) && $stable(opb));
endmodule

// File: rtl/gcd_regacc_core.sv
module gcd_regacc_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] x_q, y_q;

  // One iteration: swap when the first value is smaller, else subtract.
  function automatic logic [PAIR_W-1:0] gcd_step(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    if (x < y) return {y, x};
    else       return {x - y, y};
  endfunction

  assign done   = busy && (y_q == '0);
  assign result = x_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      x_q  <= a_in;
      y_q  <= b_in;
      busy <= 1'b1;
    end else if (busy) begin
      if (y_q == '0) busy <= 1'b0;
      else {x_q, y_q} <= gcd_step(x_q, y_q);
    end
  end

  p_zero_b_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && (b_in == '0) |=> done && (result == $past(a_in)));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/gcd_regacc_resp.sv
module gcd_regacc_resp
  import gcd_regacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPQ_W  = 8,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              start,
  input  logic              is_write,
  input  logic [OPQ_W-1:0]  opq_in,
  input  logic [ID_W-1:0]   id_in,
  input  logic              done,
  input  logic [DATA_W-1:0] result,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic              resp_write,
  output logic [DATA_W-1:0] resp_data,
  output logic [OPQ_W-1:0]  resp_opaque,
  output logic [ID_W-1:0]   resp_id
);
  logic [OPQ_W-1:0] tag_opq;
  logic [ID_W-1:0]  tag_id;
  msg_kind_e        kind_q;
  logic             immediate;

  assign immediate  = fire && !start;
  assign resp_write = (kind_q == KIND_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_opq     <= '0;
      tag_id      <= '0;
      resp_valid  <= 1'b0;
      kind_q      <= KIND_READ;
      resp_data   <= '0;
      resp_opaque <= '0;
      resp_id     <= '0;
    end else begin
      if (start) begin
        tag_opq <= opq_in;
        tag_id  <= id_in;
      end
      if (immediate) begin
        resp_valid  <= 1'b1;
        kind_q      <= is_write ? KIND_WRITE : KIND_READ;
        resp_data   <= '0;
        resp_opaque <= opq_in;
        resp_id     <= id_in;
      end else if (done) begin
        resp_valid  <= 1'b1;
        kind_q      <= KIND_READ;
        resp_data   <= result;
        resp_opaque <= tag_opq;
        resp_id     <= tag_id;
      end else if (resp_valid && resp_ready) begin
        resp_valid  <= 1'b0;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data)
      && $stable(resp_opaque) && $stable(resp_id) && $stable(resp_write));
  p_done_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> resp_valid && !resp_write && (resp_data == $past(result)));
  p_single_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(immediate && done));
endmodule

// File: rtl/gcd_regacc.sv
module gcd_regacc
  import gcd_regacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int OPQ_W  = 8,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [OPQ_W-1:0]  req_opaque,
  input  logic [ID_W-1:0]   req_id,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_write,
  output logic [DATA_W-1:0] resp_data,
  output logic [OPQ_W-1:0]  resp_opaque,
  output logic [ID_W-1:0]   resp_id,
  output logic              err_flag
);
  logic              fire, start, illegal, busy, done;
  logic [DATA_W-1:0] opa, opb, result;

  // Accept when idle and the response slot is empty or draining this cycle.
  assign req_ready = !busy && (!resp_valid || resp_ready);
  assign fire      = req_valid && req_ready;

  gcd_regacc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(req_write),
    .addr(req_addr), .data(req_data), .opa(opa), .opb(opb),
    .start(start), .illegal(illegal), .err_flag(err_flag)
  );

  gcd_regacc_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(opa), .b_in(opb),
    .busy(busy), .done(done), .result(result)
  );

  gcd_regacc_resp #(.DATA_W(DATA_W), .OPQ_W(OPQ_W), .ID_W(ID_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .start(start),
    .is_write(req_write), .opq_in(req_opaque), .id_in(req_id),
    .done(done), .result(result), .resp_ready(resp_ready),
    .resp_valid(resp_valid), .resp_write(resp_write), .resp_data(resp_data),
    .resp_opaque(resp_opaque), .resp_id(resp_id)
  );

  p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready && !resp_valid);
  p_wr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_write |=> resp_valid && resp_write && (resp_data == '0)
      && (resp_opaque == $past(req_opaque)) && (resp_id == $past(req_id)));
  p_blocked_while_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !resp_valid && !err_flag);
endmodule

// File: tb/gcd_regacc_tb.sv
module gcd_regacc_tb;
  localparam int DW = 8, AW = 4, OW = 8, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [OW-1:0] req_opaque = '0;
  logic [IW-1:0] req_id = '0;
  logic req_ready, resp_valid, resp_write, err_flag;
  logic [DW-1:0] resp_data;
  logic [OW-1:0] resp_opaque;
  logic [IW-1:0] resp_id;

  int vecs = 0, errs = 0;
  bit got_w;
  int got_d, got_o, got_i;

  always #2 clk = ~clk;

  gcd_regacc #(.DATA_W(DW), .ADDR_W(AW), .OPQ_W(OW), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .req_opaque(req_opaque), .req_id(req_id), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_write(resp_write), .resp_data(resp_data),
    .resp_opaque(resp_opaque), .resp_id(resp_id), .err_flag(err_flag)
  );

  function automatic int ref_gcd(input int a, input int b);
    int t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input int a, input int d, input int o, input int i);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a);
    req_data = DW'(d); req_opaque = OW'(o); req_id = IW'(i);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic get_resp();
    int n = 0;
    @(negedge clk);
    while (!resp_valid && n < 3000) begin @(negedge clk); n++; end
    got_w = resp_write; got_d = int'(resp_data);
    got_o = int'(resp_opaque); got_i = int'(resp_id);
    @(posedge clk);
    #1;
  endtask

  task automatic run_pair(input int a, input int b, input int tag);
    int e;
    do_req(1'b1, 1, a, tag, 1); get_resp();
    check(got_w && got_d == 0 && got_o == (tag & 8'hFF), "R2 write-A ack", got_o, tag & 8'hFF);
    do_req(1'b1, 2, b, tag + 1, 2); get_resp();
    check(got_w && got_i == 2, "R2 write-B ack", got_i, 2);
    do_req(1'b0, 0, 0, tag + 2, 5); get_resp();
    e = ref_gcd(a, b);
    check(!got_w && got_d == e, "R3/R4 gcd result", got_d, e);
    check(got_o == ((tag + 2) & 8'hFF) && got_i == 5, "R3 tag echo", got_o, (tag + 2) & 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!resp_valid, "R1 resp_valid", resp_valid, 0);
    check(req_ready, "R1 req_ready", req_ready, 1);
    check(!err_flag, "R1 err_flag", err_flag, 0);

    // R3/R4 sweep, including the zero cases
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_pair(a, b, a * 16 + b);
    run_pair(240, 180, 7);
    run_pair(255, 17, 9);
    run_pair(0, 255, 11);

    // R5 busy blocks requests
    do_req(1'b1, 1, 200, 1, 0); get_resp();
    do_req(1'b1, 2, 1, 2, 0); get_resp();
    do_req(1'b0, 0, 0, 3, 3);
    check(!req_ready, "R5 req_ready while busy", req_ready, 0);
    check(!resp_valid, "R5 no response while busy", resp_valid, 0);
    get_resp();
    check(got_d == 1 && got_o == 3, "R5 long result", got_d, 1);

    // R6 response held under backpressure
    resp_ready = 1'b0;
    do_req(1'b1, 1, 9, 8'h5A, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(resp_valid && resp_opaque == 8'h5A, "R6 held response", resp_opaque, 8'h5A);
      check(!req_ready, "R6 req_ready closed", req_ready, 0);
    end
    resp_ready = 1'b1;
    get_resp();

    // R9 drain and accept in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 1; req_data = 6; req_opaque = 1;
    @(posedge clk);
    #1 req_addr = 2; req_data = 4; req_opaque = 2;
    check(req_ready, "R9 ready while draining", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    check(resp_valid && resp_write && resp_opaque == 2, "R9 replaced response", resp_opaque, 2);
    get_resp();
    do_req(1'b0, 0, 0, 9, 1); get_resp();
    check(got_d == 2, "R9 both writes landed", got_d, 2);

    // R7 illegal accesses
    do_req(1'b1, 3, 77, 8'h33, 6); get_resp();
    check(got_w && got_o == 8'h33 && got_d == 0, "R7 illegal write ack", got_o, 8'h33);
    check(err_flag, "R7 err set", err_flag, 1);
    do_req(1'b0, 5, 0, 8'h44, 7); get_resp();
    check(!got_w && got_d == 0 && got_o == 8'h44, "R7 illegal read answer", got_d, 0);
    do_req(1'b1, 0, 99, 8'h45, 0); get_resp();
    check(got_w && got_o == 8'h45, "R7 write to result reg acked", got_o, 8'h45);
    do_req(1'b0, 0, 0, 8'h46, 2); get_resp();
    check(got_d == 2, "R7 operands unchanged", got_d, 2);

    // R8 sticky after legal traffic
    run_pair(12, 18, 20);
    check(err_flag, "R8 err sticky", err_flag, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule